// File: doc/BRIEF.md
# Read-back transparent bus latch

A word-wide, level-sensitive storage latch placed on a shared bidirectional data bus. While the latch enable is high the stored word follows the bus. When the enable is low the word is held. The stored word goes out on a separate three-state output bus whose polarity is fixed at build time, either true or bitwise inverted. Two active-low output enables must both be low for that bus to be driven.

A read-back enable, also active low, turns the stored word around onto the same data bus it was captured from. This lets the bus master confirm what was latched. The word placed on the bus is always the true stored value, whatever the output polarity. Turning read-back on or off never changes what is stored. Two active-low asynchronous controls force the stored word: clear forces all zeros and preset forces all ones. Clear wins when both are asserted.

The block sits in a clocked chip, so the held state is a register that loads on the clock while the latch is open. The open path to the outputs is combinational, so a change on the bus reaches the output bus within the same cycle. The data bus is a plain three-state net; no valid/ready flow applies here. Each tri-state net has a drive-enable output beside it.

Top module: `rb_latch`

## Requirements
- R1: While `latch_en` is high and `rdbk_n` is high, `qbus` reflects the current `dbus` value in the same cycle, with no clock edge needed.
- R2: While `latch_en` is low, the stored word keeps the bus value from the last rising clock edge at which `latch_en` was high and `rdbk_n` was high. Later bus changes do not alter it.
- R3: With `POLARITY` = `POL_TRUE`, `qbus` equals the stored word. With `POL_INV`, `qbus` equals its bitwise inverse.
- R4: `qbus_drv` is 1 exactly when `qen_a_n` and `qen_b_n` are both 0, and only then is `qbus` driven. Otherwise `qbus` is high-impedance.
- R5: While `rdbk_n` is 0, `dbus_drv` is 1 and `dbus` carries the true stored word for either polarity. While `rdbk_n` is 1, `dbus_drv` is 0 and the block does not drive `dbus`.
- R6: Read-back has no effect on storage. Toggling `rdbk_n` leaves `qbus` unchanged, and raising `latch_en` while `rdbk_n` is 0 does not change the stored word.
- R7: `preset_n` low forces every stored bit to 1 at once, without waiting for a clock edge and whatever the state of `latch_en`.
- R8: `clear_n` low forces every stored bit to 0 at once, without waiting for a clock edge, and overrides `preset_n`.
- R9: After `preset_n` or `clear_n` is released, the forced word stays stored until the latch is next opened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that updates the held register |
| clear_n | input | 1 | Asynchronous clear of the stored word, active low, dominant |
| preset_n | input | 1 | Asynchronous preset of the stored word to all ones, active low |
| latch_en | input | 1 | Latch open (transparent) when high, holding when low |
| rdbk_n | input | 1 | Read-back enable, active low, drives the stored word onto `dbus` |
| qen_a_n | input | 1 | First output enable, active low |
| qen_b_n | input | 1 | Second output enable, active low |
| dbus | inout | WIDTH | Shared data bus: captured by the latch, driven during read-back |
| qbus | output | WIDTH | Three-state output bus with the stored word in the selected polarity |
| qbus_drv | output | 1 | High while `qbus` is driven |
| dbus_drv | output | 1 | High while the block drives `dbus` |

## Verification
The assertions assume four things about the inputs. No other agent drives `dbus` while read-back is on. Preset and clear pulses span at least one rising clock edge. Bus data and controls are steady around each rising edge. The clear input is asserted from time zero. The stimulus meets all four by changing every input only on falling edges and by releasing its own bus driver in the same step that turns read-back on. A monitor reports any rising edge at which both drivers are active. The sweep covers every 8-bit word in both polarities, and the asynchronous controls are exercised mid-cycle.

// File: rtl/rbl_pkg.sv
`timescale 1ns/1ps
package rbl_pkg;

  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_INV  = 1'b1
  } pol_e;

  localparam int unsigned RBL_WIDTH_DEFAULT = 8;

endpackage

// File: rtl/rbl_cell.sv
`timescale 1ns/1ps
// One storage channel: held bit plus transparent bypass.
module rbl_cell (
  input  logic clk,
  input  logic clear_n,
  input  logic preset_n,
  input  logic load,
  input  logic d,
  output logic live,
  output logic kept
);

  logic held;

  always_ff @(posedge clk or negedge clear_n or negedge preset_n) begin
    if (!clear_n)       held <= 1'b0;
    else if (!preset_n) held <= 1'b1;
    else if (load)      held <= d;
  end

  // kept never looks at the bus, so the read-back path has no loop
  always_comb begin
    if (!clear_n)       kept = 1'b0;
    else if (!preset_n) kept = 1'b1;
    else                kept = held;
  end

  always_comb begin
    if (!clear_n)       live = 1'b0;
    else if (!preset_n) live = 1'b1;
    else if (load)      live = d;
    else                live = held;
  end

endmodule

// File: rtl/rbl_store.sv
`timescale 1ns/1ps
module rbl_store #(
  parameter int unsigned WIDTH = rbl_pkg::RBL_WIDTH_DEFAULT
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             preset_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d_word,
  output logic [WIDTH-1:0] live_word,
  output logic [WIDTH-1:0] kept_word
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_ch
    rbl_cell u_cell (
      .clk      (clk),
      .clear_n  (clear_n),
      .preset_n (preset_n),
      .load     (load),
      .d        (d_word[b]),
      .live     (live_word[b]),
      .kept     (kept_word[b])
    );
  end

endmodule

// File: rtl/rbl_drive.sv
`timescale 1ns/1ps
module rbl_drive #(
  parameter int unsigned  WIDTH    = rbl_pkg::RBL_WIDTH_DEFAULT,
  parameter rbl_pkg::pol_e POLARITY = rbl_pkg::POL_TRUE
) (
  input  logic             qen_a_n,
  input  logic             qen_b_n,
  input  logic             rdbk_n,
  input  logic [WIDTH-1:0] live_word,
  input  logic [WIDTH-1:0] kept_word,
  output logic [WIDTH-1:0] q_word,
  output logic             q_en,
  output logic [WIDTH-1:0] rb_word,
  output logic             rb_en
);

  if (POLARITY == rbl_pkg::POL_INV) begin : g_inv
    assign q_word = ~live_word;
  end else begin : g_true
    assign q_word = live_word;
  end

  assign q_en    = ~(qen_a_n | qen_b_n);
  assign rb_word = kept_word;
  assign rb_en   = ~rdbk_n;

endmodule

// File: rtl/rb_latch.sv
`timescale 1ns/1ps
module rb_latch #(
  parameter int unsigned   WIDTH    = rbl_pkg::RBL_WIDTH_DEFAULT,
  parameter rbl_pkg::pol_e POLARITY = rbl_pkg::POL_TRUE
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             preset_n,
  input  logic             latch_en,
  input  logic             rdbk_n,
  input  logic             qen_a_n,
  input  logic             qen_b_n,
  inout  wire  [WIDTH-1:0] dbus,
  output wire  [WIDTH-1:0] qbus,
  output logic             qbus_drv,
  output logic             dbus_drv
);

  logic             load;
  logic [WIDTH-1:0] live_word;
  logic [WIDTH-1:0] kept_word;
  logic [WIDTH-1:0] q_word;
  logic [WIDTH-1:0] rb_word;

  // capture is blocked while the block itself owns the bus
  assign load = latch_en & rdbk_n;

  rbl_store #(.WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .clear_n   (clear_n),
    .preset_n  (preset_n),
    .load      (load),
    .d_word    (dbus),
    .live_word (live_word),
    .kept_word (kept_word)
  );

  rbl_drive #(.WIDTH(WIDTH), .POLARITY(POLARITY)) u_drive (
    .qen_a_n   (qen_a_n),
    .qen_b_n   (qen_b_n),
    .rdbk_n    (rdbk_n),
    .live_word (live_word),
    .kept_word (kept_word),
    .q_word    (q_word),
    .q_en      (qbus_drv),
    .rb_word   (rb_word),
    .rb_en     (dbus_drv)
  );

  assign qbus = qbus_drv ? q_word  : {WIDTH{1'bz}};
  assign dbus = dbus_drv ? rb_word : {WIDTH{1'bz}};

endmodule

// File: rtl/rb_latch_chk.sv
`timescale 1ns/1ps
module rb_latch_chk #(
  parameter int unsigned   WIDTH    = rbl_pkg::RBL_WIDTH_DEFAULT,
  parameter rbl_pkg::pol_e POLARITY = rbl_pkg::POL_TRUE
) (
  input logic             clk,
  input logic             clear_n,
  input logic             preset_n,
  input logic             latch_en,
  input logic             rdbk_n,
  input logic             qen_a_n,
  input logic             qen_b_n,
  input logic [WIDTH-1:0] dbus,
  input logic [WIDTH-1:0] qbus,
  input logic             qbus_drv,
  input logic             dbus_drv
);

  function automatic logic [WIDTH-1:0] shown(input logic [WIDTH-1:0] w);
    return (POLARITY == rbl_pkg::POL_INV) ? ~w : w;
  endfunction

  // R1
  open_follow_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (latch_en && rdbk_n && preset_n && qbus_drv) |-> (qbus == shown(dbus)));

  // R2
  closed_hold_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (!latch_en && $past(!latch_en) && preset_n && $past(preset_n)
     && qbus_drv && $past(qbus_drv)) |-> $stable(qbus));

  // R4
  oe_gate_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (qen_a_n || qen_b_n) |-> !qbus_drv);

  // R5
  rb_true_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (dbus_drv && qbus_drv) |-> (dbus == shown(qbus)));

  // R6
  rb_no_load_chk: assert property (@(posedge clk) disable iff (!clear_n)
    ($past(!rdbk_n) && !rdbk_n && preset_n && $past(preset_n)
     && qbus_drv && $past(qbus_drv)) |-> $stable(qbus));

  // R7
  preset_force_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (!preset_n && qbus_drv) |-> (qbus == shown({WIDTH{1'b1}})));

  // R8
  always @(posedge clk) begin
    if (!clear_n && qbus_drv) begin
      clear_force_chk: assert (qbus == shown({WIDTH{1'b0}}));
    end
  end

endmodule

bind rb_latch rb_latch_chk #(.WIDTH(WIDTH), .POLARITY(POLARITY)) u_chk (
  .clk      (clk),
  .clear_n  (clear_n),
  .preset_n (preset_n),
  .latch_en (latch_en),
  .rdbk_n   (rdbk_n),
  .qen_a_n  (qen_a_n),
  .qen_b_n  (qen_b_n),
  .dbus     (dbus),
  .qbus     (qbus),
  .qbus_drv (qbus_drv),
  .dbus_drv (dbus_drv)
);

// File: tb/rb_latch_bench.sv
`timescale 1ns/1ps
module rb_latch_bench;

  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         clear_n  = 1'b0;
  logic         preset_n = 1'b1;
  logic         latch_en = 1'b0;
  logic         rdbk_n   = 1'b1;
  logic         qen_a_n  = 1'b0;
  logic         qen_b_n  = 1'b0;
  logic         tb_drv   = 1'b0;
  logic [W-1:0] tb_val   = '0;

  wire  [W-1:0] bus_t, bus_i, q_t, q_i;
  logic         qoe_t, rboe_t, qoe_i, rboe_i;

  assign bus_t = tb_drv ? tb_val : {W{1'bz}};
  assign bus_i = tb_drv ? tb_val : {W{1'bz}};

  rb_latch #(.WIDTH(W), .POLARITY(rbl_pkg::POL_TRUE)) u_rb_latch (
    .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .latch_en(latch_en),
    .rdbk_n(rdbk_n), .qen_a_n(qen_a_n), .qen_b_n(qen_b_n),
    .dbus(bus_t), .qbus(q_t), .qbus_drv(qoe_t), .dbus_drv(rboe_t));

  rb_latch #(.WIDTH(W), .POLARITY(rbl_pkg::POL_INV)) u_rb_latch_inv (
    .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .latch_en(latch_en),
    .rdbk_n(rdbk_n), .qen_a_n(qen_a_n), .qen_b_n(qen_b_n),
    .dbus(bus_i), .qbus(q_i), .qbus_drv(qoe_i), .dbus_drv(rboe_i));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic settle();
    #1;
  endtask

  // R5 bus contention monitor
  always @(posedge clk) begin
    if (tb_drv && (rboe_t || rboe_i)) begin
      errors++;
      $display("FAIL R5 contention actual rb=%b%b expected 00", rboe_t, rboe_i);
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state, clear held from time zero (R8)
    settle();
    chk("R8 reset true", q_t, 8'h00);
    chk("R8 reset inv", q_i, 8'hFF);
    chk1("R5 reset rb off", rboe_t, 1'b0);
    @(negedge clk); clear_n = 1'b1;

    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] w;
      w = W'(v);
      // open the latch onto the bus
      @(negedge clk);
      qen_a_n = 0; qen_b_n = 0; rdbk_n = 1; latch_en = 1; tb_drv = 1; tb_val = w;
      settle();
      chk("R1 R3 open true", q_t, w);
      chk("R1 R3 open inv", q_i, ~w);
      chk1("R4 both enables", qoe_t, 1'b1);
      // close and disturb the bus
      @(negedge clk);
      latch_en = 0; tb_val = ~w;
      settle();
      chk("R2 hold true", q_t, w);
      chk("R2 hold inv", q_i, ~w);
      // read back
      @(negedge clk);
      tb_drv = 0; rdbk_n = 0;
      settle();
      chk1("R5 rb drive", rboe_i, 1'b1);
      chk("R5 rb true", bus_t, w);
      chk("R5 rb inv build still true", bus_i, w);
      chk("R6 rb leaves q", q_t, w);
      // open latch while read-back owns the bus
      @(negedge clk);
      latch_en = 1;
      settle();
      chk("R6 open during rb", q_i, ~w);
      @(negedge clk);
      latch_en = 0; rdbk_n = 1; qen_a_n = w[0]; qen_b_n = w[1];
      settle();
      chk1("R4 enable gate", qoe_t, ~(w[0] | w[1]));
      chk1("R5 rb released", rboe_t, 1'b0);
      if (qoe_t) chk("R6 after rb stored", q_t, w);
    end

    // asynchronous controls, checked mid-cycle
    @(negedge clk);
    qen_a_n = 0; qen_b_n = 0; latch_en = 1; tb_drv = 1; tb_val = 8'h5A;
    settle();
    chk("R1 open 5A", q_t, 8'h5A);
    preset_n = 0;
    settle();
    chk("R7 preset over open", q_t, 8'hFF);
    chk("R7 preset inv", q_i, 8'h00);
    @(negedge clk);
    preset_n = 1;
    settle();
    chk("R1 back to bus", q_t, 8'h5A);
    @(negedge clk);
    latch_en = 0; tb_val = 8'h33;
    settle();
    preset_n = 0;
    settle();
    chk("R7 preset closed", q_t, 8'hFF);
    @(negedge clk);
    preset_n = 1;
    settle();
    chk("R9 preset persists", q_t, 8'hFF);
    @(negedge clk);
    tb_drv = 0; rdbk_n = 0;
    settle();
    chk("R7 preset read back", bus_i, 8'hFF);
    @(negedge clk);
    rdbk_n = 1;
    settle();
    clear_n = 0;
    settle();
    chk("R8 clear", q_t, 8'h00);
    chk("R8 clear inv", q_i, 8'hFF);
    @(negedge clk);
    preset_n = 0;
    settle();
    chk("R8 clear over preset", q_t, 8'h00);
    @(negedge clk);
    clear_n = 1;
    settle();
    chk("R7 preset after clear release", q_t, 8'hFF);
    @(negedge clk);
    preset_n = 1;
    settle();
    chk("R9 preset kept", q_t, 8'hFF);
    @(negedge clk);
    clear_n = 0;
    @(negedge clk);
    clear_n = 1;
    settle();
    chk("R9 clear persists", q_t, 8'h00);
    @(negedge clk);
    tb_drv = 1; tb_val = 8'hC3;
    settle();
    chk("R9 bus ignored while closed", q_t, 8'h00);

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule